// File: doc/BRIEF.md
# Selectable-Modulus Phase Countdown Timer

The block is a 4-bit down counter for a traffic-signal phase controller. It runs on the system clock and advances only when a one-per-second reference pulse is present as a clock enable. A mode input chooses the interval length. In long mode the counter wraps every 15 ticks, for the pass interval. In short mode it wraps every 5 ticks, for the change interval. The present count is driven out in binary. A terminal-count flag tells the phase controller that the interval has run out.

When the count is at zero, the next tick reloads the counter. The reload value is 14 or 4, depending on the mode seen on that same tick. A mode change in the middle of an interval therefore only takes effect at the next reload. Reset is asynchronous and active-low, and its release is synchronised inside the block. Reset sets the count to 14 and clears the flag.

Top module: `cdt_timer`

## Requirements
- R1: While reset is asserted, and after its release until the first tick, `count_o` is 14 and `tc_o` is 0. Asserting reset in the middle of a count forces this state without waiting for a clock edge.
- R2: A clock cycle with `tick_i` low leaves `count_o` and `tc_o` unchanged.
- R3: A tick that arrives while `count_o` is not zero lowers `count_o` by one, visible after the same clock edge.
- R4: A tick that arrives while `count_o` is 0 and `long_mode_i` is 1 reloads 14, which gives a period of 15 ticks (14 down to 0).
- R5: A tick that arrives while `count_o` is 0 and `long_mode_i` is 0 reloads 4, which gives a period of 5 ticks (4 down to 0).
- R6: Changing `long_mode_i` while the count is above zero does not change the countdown sequence. Only the reload value picked at the next zero is affected.
- R7: `tc_o` is 1 exactly while `count_o` is 0. It rises on the edge of the tick that brings the count to 0 and falls on the edge of the next tick.
- R8: `count_o` never exceeds 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-per-second reference pulse, one clock cycle wide, used as clock enable |
| long_mode_i | input | 1 | 1 selects the 15-tick interval (reload 14), 0 selects the 5-tick interval (reload 4) |
| count_o | output | 4 | Current count, binary, bit 3 most significant |
| tc_o | output | 1 | Terminal-count flag, high while the count is zero |

## Verification
The hardest cases to reach from the ports are mode changes that land close to the reload.

- **Mode flips at the edges of the reload.** One case flips the mode on the exact tick that reloads. Another flips it one tick earlier, while the count is still 1. The stimulus walks the counter down to 1 in one mode, then changes the mode on the next few ticks. This separates "sampled at the reload" from "sampled at some earlier moment".
- **Reset in the middle of a count.** An asynchronous reset is dropped between clock edges while the count is in mid-interval. The outputs are checked before the next edge arrives.
- **Consecutive ticks.** Runs of back-to-back ticks, one per clock, check that the enable path has no hidden one-cycle gap.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // Interval selection encoding on the mode input
  typedef enum logic {
    SPAN_SHORT = 1'b0,
    SPAN_LONG  = 1'b1
  } span_e;

  // Width needed to hold a reload value
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  localparam int unsigned NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] chain_q;
  logic [NS-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[NS-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[NS-1];
endmodule

// File: rtl/cdt_reload_sel.sv
module cdt_reload_sel
  import cdt_pkg::*;
#(
  parameter int unsigned W          = 4,
  parameter int unsigned LONG_LOAD  = 14,
  parameter int unsigned SHORT_LOAD = 4
) (
  input  logic         long_mode_i,
  output logic [W-1:0] load_o
);
  span_e span;

  always_comb begin
    span   = span_e'(long_mode_i);
    load_o = (span == SPAN_LONG) ? W'(LONG_LOAD) : W'(SHORT_LOAD);
  end
endmodule

// File: rtl/cdt_down_core.sv
module cdt_down_core #(
  parameter int unsigned W          = 4,
  parameter int unsigned LONG_LOAD  = 14,
  parameter int unsigned SHORT_LOAD = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         long_mode_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] count_o,
  output logic         tc_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         tc_q, tc_d;
  logic         at_zero;

  // Next-state process
  always_comb begin
    at_zero = (cnt_q == '0);
    cnt_d   = cnt_q;
    tc_d    = tc_q;
    if (tick_i) begin
      cnt_d = at_zero ? load_i : (cnt_q - W'(1));
      tc_d  = (cnt_d == '0);
    end
  end

  // Register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= W'(LONG_LOAD);
      tc_q  <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end

  assign count_o = cnt_q;
  assign tc_o    = tc_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(LONG_LOAD));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_q) && $stable(tc_q)));

  // R3 R6
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R4 R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == '0) |=>
      (cnt_q == ($past(long_mode_i) ? W'(LONG_LOAD) : W'(SHORT_LOAD))));

  // R7
  tc_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q == (cnt_q == '0));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int unsigned LONG_LOAD   = 14,
  parameter int unsigned SHORT_LOAD  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       long_mode_i,
  output logic [3:0] count_o,
  output logic       tc_o
);
  localparam int unsigned MAXL = (LONG_LOAD > SHORT_LOAD) ? LONG_LOAD : SHORT_LOAD;
  localparam int unsigned W    = cdt_pkg::cnt_width(MAXL);

  logic         rst_sync_n;
  logic [W-1:0] load_val;
  logic [W-1:0] cnt;

  cdt_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  cdt_reload_sel #(.W(W), .LONG_LOAD(LONG_LOAD), .SHORT_LOAD(SHORT_LOAD)) reload_sel_i (
    .long_mode_i (long_mode_i),
    .load_o      (load_val)
  );

  cdt_down_core #(.W(W), .LONG_LOAD(LONG_LOAD), .SHORT_LOAD(SHORT_LOAD)) core_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .tick_i      (tick_i),
    .long_mode_i (long_mode_i),
    .load_i      (load_val),
    .count_o     (cnt),
    .tc_o        (tc_o)
  );

  assign count_o = 4'(cnt);
endmodule

// File: tb/cdt_timer_tb.sv
`timescale 1ns/1ps
module cdt_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       mode;
  logic [3:0] count;
  logic       tc;

  always #2.5 clk = ~clk;

  cdt_timer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .long_mode_i (mode),
    .count_o     (count),
    .tc_o        (tc)
  );

  typedef struct {
    int    cnt;
    bit    tcv;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   fails  = 0;
  int   m_cnt  = 14;
  bit   done   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one clock cycle of stimulus, expected result pushed to scoreboard
  task automatic step(input bit t, input bit m, input string tag_ovr);
    exp_t  e;
    string tg;
    @(negedge clk);
    tick = t;
    mode = m;
    if (t && m_cnt == 0)      begin tg = m ? "R4" : "R5"; m_cnt = m ? 14 : 4; end
    else if (t)               begin tg = "R3"; m_cnt = m_cnt - 1; end
    else                      tg = "R2";
    if (tag_ovr != "") tg = tag_ovr;
    e.cnt = m_cnt;
    e.tcv = (m_cnt == 0);
    e.tag = tg;
    sb_q.push_back(e);
  endtask

  task automatic ticks(input int n, input bit m);
    for (int i = 0; i < n; i++) step(1'b1, m, "");
  endtask

  task automatic drain();
    step(1'b0, mode, "");
    while (sb_q.size() != 0) @(posedge clk);
    #2;
  endtask

  // Monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(count == 4'(e.cnt), e.tag, count, e.cnt);
        chk(tc == e.tcv, "R7", tc, e.tcv);
        chk(count <= 4'd14, "R8", count, 14);
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; mode = 1'b1;
    repeat (3) @(negedge clk);
    // R1 during reset, even with tick high
    tick = 1'b1;
    @(negedge clk);
    chk(count == 4'd14, "R1", count, 14);
    chk(tc == 1'b0, "R1", tc, 0);
    tick = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(count == 4'd14, "R1", count, 14);
    chk(tc == 1'b0, "R1", tc, 0);

    // Long mode, two full periods with idle gaps
    for (int i = 0; i < 30; i++) begin
      step(1'b1, 1'b1, "");
      if (i % 4 == 0) step(1'b0, 1'b1, "");
    end
    // count now 14 again; R6: switch to short mid-count
    ticks(3, 1'b1);
    for (int i = 0; i < 11; i++) step(1'b1, 1'b0, (m_cnt > 0) ? "R6" : "");
    // Short periods
    ticks(12, 1'b0);
    // Drive down to 1 in short mode, then flip on the reload tick
    while (m_cnt != 1) step(1'b1, 1'b0, "");
    step(1'b1, 1'b1, "R6");
    step(1'b1, 1'b1, "R4");
    ticks(14, 1'b1);
    // at 0; flip to short exactly at reload
    step(1'b1, 1'b0, "R5");
    ticks(6, 1'b0);
    drain();

    // R1: asynchronous reset mid-count
    while (m_cnt != 7 && m_cnt != 2) step(1'b1, 1'b1, "");
    drain();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(count == 4'd14, "R1", count, 14);
    chk(tc == 1'b0, "R1", tc, 0);
    m_cnt = 14;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(count == 4'd14, "R1", count, 14);
    ticks(16, 1'b1);
    step(1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, "R2");
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule